// File: doc/BRIEF.md
# Fractional-N Divide Ratio Controller

This block works out, for every reference period of a fractional-N synthesizer loop, the whole-number ratio the feedback divider should use next. A modular accumulator adds the fractional numerator on each reference strobe. When the running sum reaches the programmed denominator, the denominator is taken away and that period's ratio is raised by one. Over a full cycle of the denominator, the mean ratio is the integer part plus the numerator over the denominator.

Each chosen ratio is also split into a main count and a swallow count for a dual-modulus prescaler. The prescaler runs in one of two modes: divide-by-4/5 or divide-by-8/9. The block compares the integer part against the lowest ratio the selected mode allows and raises a configuration flag when a setting is illegal. When the low-spur noise mode is selected, it can spread quantisation spurs by adding a one-bit pseudo-random dither to the accumulator. The denominator is staged: a newly written value takes effect only on an explicit apply pulse. A hold input keeps the loop counters in their load state while the synthesizer is being set up.

Top module: `frac_ratio_ctrl`

## Requirements
- R1: A step is a clock edge where `ref_stb` is 1, `cnt_hold` is 0 and `mod_apply` is 0. At each step the effective numerator (and the dither bit, if any) is added to the accumulator. If the sum is at least the active denominator, the denominator is subtracted and the carry is 1. Otherwise the carry is 0. On the following cycle `ratio_out` equals the effective integer plus the carry, `carry_out` shows the carry, and `ratio_vld` is 1 for that one cycle only.
- R2: With no dither, starting from an empty accumulator, any run of `mod` steps produces exactly `frac` carries when `frac` ≤ `mod`.
- R3: When `frac_val` is greater than the active denominator, the numerator is clamped to the denominator, so every step carries.
- R4: `psc_sel` = 0 selects divide-by-4/5, where the lowest legal integer is 31. `psc_sel` = 1 selects divide-by-8/9, where it is 91. An `int_val` below the limit is replaced by the limit.
- R5: While the active denominator is 0, steps never carry and the accumulator stays at 0.
- R6: Whenever `ratio_out` is updated, `main_cnt` = ratio / P and `swal_cnt` = ratio mod P are updated with it, where P is 4 when `psc_sel` = 0 and 8 when `psc_sel` = 1.
- R7: Dither is used only when `noise_mode` = 2'b10 (low spur). Codes 2'b00 (lowest noise), 2'b01 (low noise and spur) and 2'b11 never dither. The dither bit is bit 0 of a 15-bit LFSR with seed 1. At each step the LFSR shifts left, and the new bit 0 is the XOR of old bits 14 and 13. The dither bit is added only when the effective numerator is below the denominator.
- R8: While `cnt_hold` is 1, the accumulator is cleared and the LFSR is returned to its seed. `ratio_out` follows the effective integer with `carry_out` = 0. `ratio_vld` stays 0 and strobes are ignored.
- R9: The active denominator loads `mod_val` only on a cycle where `mod_apply` is 1, and the accumulator is cleared on that cycle. A strobe on that same cycle is not taken as a step. Changes to `mod_val` at any other time have no effect.
- R10: While reset is asserted, all outputs are 0 and the active denominator is 0.
- R11: One cycle after its inputs, `cfg_err` is 1 if the integer is below the limit, or the numerator exceeds the active denominator, or the active denominator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_stb | input | 1 | One-cycle strobe per reference period |
| cnt_hold | input | 1 | Hold counters in load state |
| mod_apply | input | 1 | Load staged denominator |
| psc_sel | input | 1 | 0: divide-by-4/5, 1: divide-by-8/9 |
| noise_mode | input | 2 | Noise/spur mode code |
| int_val | input | 9 | Integer part of the ratio |
| frac_val | input | 12 | Fractional numerator |
| mod_val | input | 12 | Staged denominator |
| ratio_out | output | 10 | Ratio chosen for the current period |
| carry_out | output | 1 | Accumulator carry of the last step |
| ratio_vld | output | 1 | New ratio present this cycle |
| main_cnt | output | 8 | Main prescaler count |
| swal_cnt | output | 3 | Swallow count |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The assertions assume that `mod_apply` is a single-cycle pulse from an already synchronized source, and that the configuration inputs are held steady around each strobe. In stimulus, every input changes only on the falling clock edge, and a staged denominator is always followed by an apply pulse. Strobes are spaced at least one cycle apart.

The bench deliberately overlaps a strobe with an apply pulse, and a strobe with the hold input. It also covers numerators above the denominator, a zero denominator, and integers below both prescaler limits, to reach the clamp and error paths.

// File: rtl/frac_pkg.sv
// Shared definitions for the fractional divide ratio controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package frac_pkg;
    typedef enum logic [1:0] {
        NM_LOWEST   = 2'b00,
        NM_NOISESPR = 2'b01,
        NM_LOWSPUR  = 2'b10,
        NM_SPARE    = 2'b11
    } noise_mode_e;
endpackage

// File: rtl/frac_lfsr.sv
// Pseudo-random dither source: Fibonacci LFSR shifted left once per step.
// Assumes SEED is nonzero and both taps lie inside the register.
module frac_lfsr #(
    parameter int W     = 15,
    parameter int SEED  = 1,
    parameter int TAP_A = 14,
    parameter int TAP_B = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic rnd_bit
);
    localparam logic [W-1:0] SEED_V = W'(SEED);

    logic [W-1:0] q;
    logic         fb;

    // Purpose: feedback bit from the two taps.
    always_comb fb = q[TAP_A] ^ q[TAP_B];

    // Purpose: reseed on reset or clear, advance on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= SEED_V;
        else if (adv)
            q <= {q[W-2:0], fb};
    end

    assign rnd_bit = q[0];

    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
endmodule

// File: rtl/frac_accum.sv
// Modular phase accumulator with a staged denominator register.
// Assumes mod_apply is a synchronized single-cycle pulse.
module frac_accum #(
    parameter int FW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          mod_apply,
    input  logic [FW-1:0] mod_in,
    input  logic          step,
    input  logic [FW-1:0] frac_in,
    input  logic          dith_in,
    output logic          carry_now,
    output logic          frac_over,
    output logic          mod_zero
);
    localparam int SW = FW + 2;

    logic [FW-1:0] acc;
    logic [FW-1:0] mod_act;
    logic [FW-1:0] frac_eff;
    logic          dith_use;
    logic [SW-1:0] sum;

    // Purpose: clamp numerator, gate dither, form the sum and carry.
    always_comb begin
        frac_over = frac_in > mod_act;
        mod_zero  = mod_act == '0;
        frac_eff  = frac_over ? mod_act : frac_in;
        dith_use  = dith_in && (frac_eff < mod_act);
        sum       = SW'(acc) + SW'(frac_eff) + SW'(dith_use);
        carry_now = !mod_zero && (sum >= SW'(mod_act));
    end

    // Purpose: active denominator loads only on the apply pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mod_act <= '0;
        else if (mod_apply)
            mod_act <= mod_in;
    end

    // Purpose: accumulator register, cleared by hold or apply.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || mod_apply)
            acc <= '0;
        else if (step && !mod_zero)
            acc <= carry_now ? FW'(sum - SW'(mod_act)) : FW'(sum);
    end

    a_r1_acc_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_zero |-> acc < mod_act);
    a_r5_zero_mod_empty: assert property (@(posedge clk) disable iff (!rst_n)
        mod_zero |-> acc == '0);
    a_r9_mod_only_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_apply |=> $stable(mod_act));
endmodule

// File: rtl/frac_split.sv
// Splits a ratio into main and swallow counts for a two-mode prescaler.
// Assumes both prescaler moduli are powers of two given by their log2.
module frac_split #(
    parameter int RW     = 10,
    parameter int LO_LOG = 2,
    parameter int HI_LOG = 3
) (
    input  logic              hi_sel,
    input  logic [RW-1:0]     ratio,
    output logic [RW-LO_LOG-1:0] main_c,
    output logic [HI_LOG-1:0] swal_c
);
    localparam int MW = RW - LO_LOG;

    logic [MW-1:0]     main_lo, main_hi;
    logic [HI_LOG-1:0] swal_lo, swal_hi;

    // Purpose: quotient and remainder for each prescaler mode.
    always_comb begin
        main_lo = MW'(ratio >> LO_LOG);
        main_hi = MW'(ratio >> HI_LOG);
        swal_lo = HI_LOG'(ratio[LO_LOG-1:0]);
        swal_hi = ratio[HI_LOG-1:0];
    end

    // Purpose: pick the mode in use.
    always_comb begin
        main_c = hi_sel ? main_hi : main_lo;
        swal_c = hi_sel ? swal_hi : swal_lo;
    end
endmodule

// File: rtl/frac_ratio_ctrl.sv
// Top: per-period fractional-N divide ratio with floor check, dither and
// prescaler split. Assumes inputs are synchronous to clk and mod_apply is
// a single-cycle pulse; outputs are registered.
module frac_ratio_ctrl
    import frac_pkg::*;
#(
    parameter int INT_W   = 9,
    parameter int FRAC_W  = 12,
    parameter int LFSR_W  = 15,
    parameter int SEED    = 1,
    parameter int NMIN_LO = 31,
    parameter int NMIN_HI = 91,
    parameter int LO_LOG  = 2,
    parameter int HI_LOG  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_stb,
    input  logic              cnt_hold,
    input  logic              mod_apply,
    input  logic              psc_sel,
    input  logic [1:0]        noise_mode,
    input  logic [8:0]        int_val,
    input  logic [11:0]       frac_val,
    input  logic [11:0]       mod_val,
    output logic [9:0]        ratio_out,
    output logic              carry_out,
    output logic              ratio_vld,
    output logic [7:0]        main_cnt,
    output logic [2:0]        swal_cnt,
    output logic              cfg_err
);
    localparam int RW = INT_W + 1;
    localparam int MW = RW - LO_LOG;

    logic [INT_W-1:0] nmin;
    logic [INT_W-1:0] int_eff;
    logic             int_low;
    logic             step;
    logic             dith_en;
    logic             rnd_bit;
    logic             carry_now;
    logic             frac_over;
    logic             mod_zero;
    logic [RW-1:0]    ratio_d;
    logic [MW-1:0]    main_d;
    logic [HI_LOG-1:0] swal_d;

    // Purpose: floor for the chosen prescaler and clamped integer.
    always_comb begin
        nmin    = psc_sel ? INT_W'(NMIN_HI) : INT_W'(NMIN_LO);
        int_low = int_val < nmin;
        int_eff = int_low ? nmin : int_val;
    end

    // Purpose: qualify a step and the dither enable.
    always_comb begin
        step    = ref_stb && !cnt_hold && !mod_apply;
        dith_en = noise_mode == NM_LOWSPUR;
    end

    frac_lfsr #(.W(LFSR_W), .SEED(SEED), .TAP_A(LFSR_W-1), .TAP_B(LFSR_W-2)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_hold),
        .adv     (step),
        .rnd_bit (rnd_bit)
    );

    frac_accum #(.FW(FRAC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_hold),
        .mod_apply (mod_apply),
        .mod_in    (mod_val),
        .step      (step),
        .frac_in   (frac_val),
        .dith_in   (rnd_bit && dith_en),
        .carry_now (carry_now),
        .frac_over (frac_over),
        .mod_zero  (mod_zero)
    );

    // Purpose: ratio for this step, or load value while held.
    always_comb ratio_d = RW'(int_eff) + RW'(carry_now && !cnt_hold);

    frac_split #(.RW(RW), .LO_LOG(LO_LOG), .HI_LOG(HI_LOG)) u_split (
        .hi_sel (psc_sel),
        .ratio  (ratio_d),
        .main_c (main_d),
        .swal_c (swal_d)
    );

    // Purpose: output registers for ratio, counts and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_out <= '0;
            carry_out <= 1'b0;
            ratio_vld <= 1'b0;
            main_cnt  <= '0;
            swal_cnt  <= '0;
        end else if (cnt_hold || step) begin
            ratio_out <= ratio_d;
            carry_out <= carry_now && !cnt_hold;
            ratio_vld <= step;
            main_cnt  <= main_d;
            swal_cnt  <= swal_d;
        end else begin
            ratio_vld <= 1'b0;
        end
    end

    // Purpose: registered configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else
            cfg_err <= int_low || frac_over || mod_zero;
    end

    a_r1_ratio_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_vld |-> ratio_out == RW'($past(int_eff)) + RW'(carry_out));
    a_r4_ratio_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_vld |-> ratio_out >= RW'($past(nmin)));
    a_r6_split_sum: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_vld |-> ratio_out == ($past(psc_sel) ? (RW'(main_cnt) << HI_LOG)
                                                    : (RW'(main_cnt) << LO_LOG)) + RW'(swal_cnt));
    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hold |=> !ratio_vld && !carry_out);
endmodule

// File: tb/tb_frac_ratio_ctrl.sv
module tb_frac_ratio_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_stb = 1'b0, cnt_hold = 1'b0, mod_apply = 1'b0, psc_sel = 1'b0;
    logic [1:0] noise_mode = 2'b00;
    logic [8:0] int_val = '0;
    logic [11:0] frac_val = '0, mod_val = '0;
    logic [9:0] ratio_out;
    logic       carry_out, ratio_vld, cfg_err;
    logic [7:0] main_cnt;
    logic [2:0] swal_cnt;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    frac_ratio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .cnt_hold(cnt_hold),
        .mod_apply(mod_apply), .psc_sel(psc_sel), .noise_mode(noise_mode),
        .int_val(int_val), .frac_val(frac_val), .mod_val(mod_val),
        .ratio_out(ratio_out), .carry_out(carry_out), .ratio_vld(ratio_vld),
        .main_cnt(main_cnt), .swal_cnt(swal_cnt), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_acc, m_mod, m_lfsr, m_ratio, m_carry, m_vld, m_err, m_psc;
    bit m_live = 0;

    always @(posedge clk) begin
        int nmin, ie, fe, d, s, nmod;
        m_live = 1;
        if (!rst_n) begin
            m_acc = 0; m_mod = 0; m_lfsr = 1; m_ratio = 0; m_carry = 0;
            m_vld = 0; m_err = 0; m_psc = 0;
        end else begin
            nmin = psc_sel ? 91 : 31;
            ie = (int_val < nmin) ? nmin : int_val;
            fe = (frac_val > m_mod) ? m_mod : frac_val;
            nmod = m_mod;
            m_err = (int_val < nmin) || (frac_val > m_mod) || (m_mod == 0);
            if (mod_apply) nmod = mod_val;
            if (cnt_hold) begin
                m_acc = 0; m_lfsr = 1; m_ratio = ie; m_carry = 0; m_vld = 0; m_psc = psc_sel;
            end else if (mod_apply) begin
                m_acc = 0; m_vld = 0;
            end else if (ref_stb) begin
                d = (noise_mode == 2'b10 && fe < m_mod) ? (m_lfsr & 1) : 0;
                if (m_mod == 0) begin
                    m_carry = 0; m_acc = 0;
                end else begin
                    s = m_acc + fe + d;
                    m_carry = (s >= m_mod) ? 1 : 0;
                    m_acc = m_carry ? s - m_mod : s;
                end
                m_lfsr = ((m_lfsr << 1) | (((m_lfsr >> 14) ^ (m_lfsr >> 13)) & 1)) & 32'h7FFF;
                m_ratio = ie + m_carry; m_vld = 1; m_psc = psc_sel;
            end else begin
                m_vld = 0;
            end
            if (mod_apply) m_acc = 0;
            m_mod = nmod;
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (m_live && !done) begin
            chk("R1 ratio", ratio_out, m_ratio);
            chk("R1 carry", carry_out, m_carry);
            chk("R1 vld", ratio_vld, m_vld);
            chk("R6 main", main_cnt, m_psc ? m_ratio / 8 : m_ratio / 4);
            chk("R6 swal", swal_cnt, m_psc ? m_ratio % 8 : m_ratio % 4);
            chk("R11 err", cfg_err, m_err);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_stb();
        ref_stb = 1'b1; @(negedge clk); ref_stb = 1'b0;
    endtask

    task automatic apply_mod(input int v);
        mod_val = 12'(v); mod_apply = 1'b1; @(negedge clk); mod_apply = 1'b0;
    endtask

    task automatic hold_pulse();
        cnt_hold = 1'b1; @(negedge clk); cnt_hold = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int carries;
        cyc(3);
        // R10: reset state
        chk("R10 ratio", ratio_out, 0);
        chk("R10 vld", ratio_vld, 0);
        chk("R10 err", cfg_err, 0);
        chk("R10 main", main_cnt, 0);
        rst_n = 1'b1;
        int_val = 9'd138; frac_val = 12'd30; psc_sel = 1'b1;
        cyc(1);
        chk("R11 zero-mod err", cfg_err, 1);
        apply_mod(65);
        cyc(1);
        chk("R11 err cleared", cfg_err, 0);

        // R2: 65 steps give 30 carries
        carries = 0;
        for (int i = 0; i < 65; i++) begin
            pulse_stb();
            if (ratio_vld && carry_out) carries++;
            cyc(1);
        end
        chk("R2 carries", carries, 30);

        // R8: hold load state, strobes ignored
        cnt_hold = 1'b1; cyc(1);
        chk("R8 ratio", ratio_out, 138);
        chk("R6 main 8/9", main_cnt, 17);
        chk("R6 swal 8/9", swal_cnt, 2);
        pulse_stb();
        chk("R8 vld", ratio_vld, 0);
        // R4: floors
        int_val = 9'd50; cyc(1);
        chk("R4 floor 91", ratio_out, 91);
        chk("R4 err", cfg_err, 1);
        psc_sel = 1'b0; cyc(1);
        chk("R4 no floor", ratio_out, 50);
        chk("R6 main 4/5", main_cnt, 12);
        chk("R6 swal 4/5", swal_cnt, 2);
        int_val = 9'd20; cyc(1);
        chk("R4 floor 31", ratio_out, 31);
        cnt_hold = 1'b0; int_val = 9'd138; psc_sel = 1'b1;

        // R3: numerator above denominator
        frac_val = 12'd100;
        for (int i = 0; i < 3; i++) begin
            pulse_stb();
            chk("R3 ratio", ratio_out, 139);
            chk("R3 err", cfg_err, 1);
        end

        // R7: dither only in low-spur mode
        frac_val = 12'd2;
        hold_pulse(); apply_mod(3);
        noise_mode = 2'b10; pulse_stb();
        chk("R7 dither on", ratio_out, 139);
        hold_pulse(); noise_mode = 2'b01; pulse_stb();
        chk("R7 dither off", ratio_out, 138);
        hold_pulse(); noise_mode = 2'b11; pulse_stb();
        chk("R7 spare code", ratio_out, 138);
        noise_mode = 2'b00;

        // R9: staged denominator without apply has no effect
        apply_mod(65);
        mod_val = 12'd3;
        hold_pulse();
        pulse_stb(); pulse_stb();
        chk("R9 no apply", ratio_out, 138);
        // R9: strobe on apply cycle not taken
        mod_val = 12'd65; ref_stb = 1'b1; mod_apply = 1'b1; @(negedge clk);
        ref_stb = 1'b0; mod_apply = 1'b0;
        chk("R9 apply blocks step", ratio_vld, 0);

        // R5: zero denominator
        frac_val = 12'd0; apply_mod(0);
        for (int i = 0; i < 3; i++) begin
            pulse_stb();
            chk("R5 no carry", carry_out, 0);
            chk("R5 err", cfg_err, 1);
        end

        // Long dithered runs, both prescalers
        frac_val = 12'd30; apply_mod(65); noise_mode = 2'b10;
        for (int i = 0; i < 200; i++) begin pulse_stb(); cyc(i % 3); end
        psc_sel = 1'b0; int_val = 9'd40; frac_val = 12'd4000; apply_mod(4095);
        for (int i = 0; i < 200; i++) begin pulse_stb(); end
        frac_val = 12'd4095;
        for (int i = 0; i < 20; i++) begin pulse_stb(); end
        cyc(2);
        finish_run();
    end
endmodule